// File: doc/BRIEF.md
# Multiframe-Count Differential Delay Aligner

This block puts back together a small group of payload paths that reached the receiver with different network delays. Each member path delivers one payload byte at a time. Every byte carries the 12-bit multiframe count that the sender stamped on it, and each member also has a provisioned sequence number. Each member gets its own circular buffer, and every byte is stored there with its count tag. The controller finds the most recent count that every member holds. It then reads all buffers in lockstep at that count. This delays each member to match the slowest one. It rebuilds a single byte stream by taking one byte per member in ascending sequence-number order.

Counts are compared modulo 4096. A forward distance of 1 to 2047 means "later" and anything else means "earlier". The group therefore tolerates any differential delay below half the count range. Each member's buffer occupancy is visible, and it measures how far that member runs ahead of the most-delayed one. An overflow alarm fires when a member gets too far ahead. A configuration error blocks the output when the sequence numbers are not a clean permutation of 0..N-1.

The controller has four states. ALIGN waits until every buffer is non-empty, latches the latest head count as the target, and moves to TRIM. TRIM discards head bytes older than the target. It moves to READ once every head equals the target, or back to ALIGN if any head is beyond the target. READ emits one byte per cycle in sequence order and advances the target after the last sequence number. It drops to ALIGN when the needed head is present but not at the target. CFGERR is entered from any state when the sequence numbers are invalid, and it leaves to ALIGN once they are valid. Any overflow empties all buffers and forces ALIGN. Reset enters ALIGN.

Top module: `vcg_deskew`

## Requirements
- R1: After reset, out_valid, ovf_alarm and cfg_err are 0 and every mem_depth is 0.
- R2: A member's byte with in_valid high is stored with its count tag in that member's own buffer. mem_depth for that member rises by one, and the other members are unaffected.
- R3: The first byte output after alignment carries the latest head count among the members. Older bytes in lagging members are discarded.
- R4: For each count, exactly one byte per member is output, in ascending sequence number (cfg_seq value 0 first). out_mfi increments by 1 modulo 4096 after the byte with sequence number N-1.
- R5: Count comparison is modular. A forward distance of 2048 or more counts as earlier, so alignment works across the 4095 to 0 wrap.
- R6: Once the most-delayed member runs empty, every other member's mem_depth equals its count lead over the most-delayed member.
- R7: While the buffer of the member whose sequence number is next is empty, no byte is output and all depths hold.
- R8: A write to a full buffer raises ovf_alarm for one cycle. In that same cycle every mem_depth reads 0, and the group realigns.
- R9: If the cfg_seq values are not a permutation of 0..N-1, cfg_err is 1 and no byte is output, though writes are still stored. Once the values are fixed, alignment and output resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-member byte strobe |
| in_data | input | N*8 | Per-member payload byte |
| in_mfi | input | N*12 | Per-member multiframe count of the byte |
| cfg_seq | input | N*SEQ_W | Provisioned sequence number of each member |
| out_valid | output | 1 | Reassembled byte valid |
| out_data | output | 8 | Reassembled byte |
| out_mfi | output | 12 | Count of the output byte |
| out_seq | output | SEQ_W | Sequence number of the output byte |
| mem_depth | output | N*CNT_W | Bytes held per member |
| ovf_alarm | output | 1 | One-cycle excess-delay alarm |
| cfg_err | output | 1 | Sequence numbers invalid |

## Verification
The bench uses members with permuted sequence numbers, so a design that reassembled bytes by port index would emit the wrong data at the first comparison. One run places the lagging member just before the 4095 wrap while the leading member sits past it. A plain magnitude compare would pick the wrong target there and emit a different first count. After the input stops, the per-member depths are checked against the count offsets, and the output must stay silent while the slowest member is empty. A lead larger than the buffer must produce an alarm with all buffers empty, and a duplicated sequence number must block output until it is corrected.

// File: rtl/vcg_align_pkg.sv
package vcg_align_pkg;
    localparam int MFI_W = 12;
    typedef logic [MFI_W-1:0] mfi_t;

    typedef enum logic [1:0] {
        S_CFGERR,
        S_ALIGN,
        S_TRIM,
        S_READ
    } align_state_e;

    // a is later than b when the forward distance lies in 1..half-range-1
    function automatic logic mfi_later(input mfi_t a, input mfi_t b);
        mfi_t d;
        d = a - b;
        return (d != '0) && !d[MFI_W-1];
    endfunction
endpackage

// File: rtl/vcg_member_buf.sv
module vcg_member_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int TW    = 12,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [TW-1:0] wr_tag,
    input  logic          rd_en,
    output logic [DW-1:0] head_data,
    output logic [TW-1:0] head_tag,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem_d [DEPTH];
    logic [TW-1:0] mem_t [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    assign do_wr = wr_en && (count != CW'(DEPTH)) && !flush;
    assign do_rd = rd_en && (count != '0) && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_d[wr_ptr] <= wr_data;
            mem_t[wr_ptr] <= wr_tag;
        end
    end

    assign head_data = mem_d[rd_ptr];
    assign head_tag  = mem_t[rd_ptr];

    a_r2_depth_limit: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r2_read_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (count != '0));
endmodule

// File: rtl/vcg_seq_check.sv
module vcg_seq_check #(
    parameter int N  = 4,
    parameter int SW = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0][SW-1:0] seq,
    output logic                 ok,
    output logic [N-1:0][IW-1:0] mem_of_seq
);
    always_comb begin
        int hits;
        ok = 1'b1;
        for (int s = 0; s < N; s++) begin
            hits          = 0;
            mem_of_seq[s] = '0;
            for (int m = 0; m < N; m++) begin
                if (seq[m] == SW'(s)) begin
                    hits          = hits + 1;
                    mem_of_seq[s] = IW'(m);
                end
            end
            if (hits != 1) ok = 1'b0;
        end
    end
endmodule

// File: rtl/vcg_deskew.sv
module vcg_deskew #(
    parameter int N     = 4,
    parameter int DEPTH = 16,
    parameter int SEQ_W = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            in_valid,
    input  logic [N-1:0][7:0]       in_data,
    input  logic [N-1:0][11:0]      in_mfi,
    input  logic [N-1:0][SEQ_W-1:0] cfg_seq,
    output logic                    out_valid,
    output logic [7:0]              out_data,
    output logic [11:0]             out_mfi,
    output logic [SEQ_W-1:0]        out_seq,
    output logic [N-1:0][CNT_W-1:0] mem_depth,
    output logic                    ovf_alarm,
    output logic                    cfg_err
);
    import vcg_align_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    align_state_e         state, nxt;
    mfi_t                 target, target_nxt, best;
    logic [IW-1:0]        rd_idx, rd_nxt, sel;
    logic [N-1:0]         empty_v, full_v, pop_v;
    logic [7:0]           head_data [N];
    mfi_t                 head_mfi  [N];
    logic [N-1:0][IW-1:0] mem_of_seq;
    logic                 cfg_ok, any_ovf, all_at, any_ahead, sel_ready;

    for (genvar m = 0; m < N; m++) begin : g_mem
        vcg_member_buf #(.DEPTH(DEPTH), .DW(8), .TW(MFI_W), .CW(CNT_W)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (any_ovf),
            .wr_en    (in_valid[m]),
            .wr_data  (in_data[m]),
            .wr_tag   (in_mfi[m]),
            .rd_en    (pop_v[m]),
            .head_data(head_data[m]),
            .head_tag (head_mfi[m]),
            .count    (mem_depth[m])
        );
        assign empty_v[m] = (mem_depth[m] == '0);
        assign full_v[m]  = (mem_depth[m] == CNT_W'(DEPTH));
    end

    vcg_seq_check #(.N(N), .SW(SEQ_W), .IW(IW)) u_seq (
        .seq       (cfg_seq),
        .ok        (cfg_ok),
        .mem_of_seq(mem_of_seq)
    );

    assign any_ovf   = |(in_valid & full_v);
    assign sel       = mem_of_seq[rd_idx];
    assign sel_ready = !empty_v[sel] && (head_mfi[sel] == target);

    // next state, target and pops
    always_comb begin
        nxt        = state;
        target_nxt = target;
        rd_nxt     = rd_idx;
        pop_v      = '0;
        best       = head_mfi[0];
        all_at     = 1'b1;
        any_ahead  = 1'b0;
        for (int m = 0; m < N; m++) begin
            if (mfi_later(head_mfi[m], best)) best = head_mfi[m];
            if (empty_v[m] || head_mfi[m] != target) all_at = 1'b0;
            if (!empty_v[m] && mfi_later(head_mfi[m], target)) any_ahead = 1'b1;
        end
        unique case (state)
            S_CFGERR: if (cfg_ok) nxt = S_ALIGN;
            S_ALIGN: begin
                if (empty_v == '0) begin
                    nxt        = S_TRIM;
                    target_nxt = best;
                end
            end
            S_TRIM: begin
                for (int m = 0; m < N; m++)
                    if (!empty_v[m] && mfi_later(target, head_mfi[m])) pop_v[m] = 1'b1;
                if (all_at) begin
                    nxt    = S_READ;
                    rd_nxt = '0;
                end else if (any_ahead) begin
                    nxt = S_ALIGN;
                end
            end
            S_READ: begin
                if (sel_ready) begin
                    pop_v[sel] = 1'b1;
                    if (rd_idx == IW'(N - 1)) begin
                        rd_nxt     = '0;
                        target_nxt = target + 1'b1;
                    end else begin
                        rd_nxt = rd_idx + 1'b1;
                    end
                end else if (!empty_v[sel]) begin
                    nxt = S_ALIGN;
                end
            end
            default: nxt = S_ALIGN;
        endcase
        if (!cfg_ok) begin
            nxt   = S_CFGERR;
            pop_v = '0;
        end else if (any_ovf) begin
            nxt   = S_ALIGN;
            pop_v = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_ALIGN;
            target <= '0;
            rd_idx <= '0;
        end else begin
            state  <= nxt;
            target <= target_nxt;
            rd_idx <= rd_nxt;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_mfi   <= '0;
            out_seq   <= '0;
            ovf_alarm <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            out_valid <= (state == S_READ) && (|pop_v);
            out_data  <= head_data[sel];
            out_mfi   <= target;
            out_seq   <= SEQ_W'(rd_idx);
            ovf_alarm <= any_ovf;
            cfg_err   <= !cfg_ok;
        end
    end

    a_r9_cfg_blocks_output: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> !out_valid);

    a_r8_alarm_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_alarm |-> (mem_depth == '0));

    a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && out_mfi == $past(out_mfi))
            |-> out_seq == SEQ_W'($past(out_seq) + 1'b1));

    a_r4_mfi_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && $past(out_seq) == SEQ_W'(N - 1))
            |-> out_mfi == 12'($past(out_mfi) + 1'b1));
endmodule

// File: tb/vcg_deskew_bench.sv
module vcg_deskew_bench;
    localparam int N = 4;
    localparam int DEPTH = 16;
    localparam int SEQ_W = 3;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] in_valid = '0;
    logic [N-1:0][7:0] in_data = '0;
    logic [N-1:0][11:0] in_mfi = '0;
    logic [N-1:0][SEQ_W-1:0] cfg_seq;
    logic out_valid;
    logic [7:0] out_data;
    logic [11:0] out_mfi;
    logic [SEQ_W-1:0] out_seq;
    logic [N-1:0][CNT_W-1:0] mem_depth;
    logic ovf_alarm, cfg_err;

    always #4 clk = ~clk;

    vcg_deskew #(.N(N), .DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_vcg_deskew (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_mfi(in_mfi), .cfg_seq(cfg_seq), .out_valid(out_valid),
        .out_data(out_data), .out_mfi(out_mfi), .out_seq(out_seq),
        .mem_depth(mem_depth), .ovf_alarm(ovf_alarm), .cfg_err(cfg_err)
    );

    int total = 0, bad = 0;
    int base [N];
    int seqv [N];
    int exp_mfi[$], exp_seq[$], exp_dat[$];
    bit cmp_en = 0;
    int first_mfi = -1, valid_seen = 0, alarm_cnt = 0, alarm_dirty = 0;
    bit done = 0;

    function automatic int dfun(int m, int c);
        return (m * 61 + (c % 4096) * 3 + 1) % 256;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic apply_seq();
        for (int m = 0; m < N; m++) cfg_seq[m] = SEQ_W'(seqv[m]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmp_en = 0;
        in_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        first_mfi = -1; valid_seen = 0; alarm_cnt = 0; alarm_dirty = 0;
        exp_mfi.delete(); exp_seq.delete(); exp_dat.delete();
    endtask

    task automatic tick(input int k, input logic [N-1:0] mask);
        for (int m = 0; m < N; m++) begin
            in_mfi[m]  = 12'((base[m] + k) % 4096);
            in_data[m] = 8'(dfun(m, base[m] + k));
        end
        in_valid = mask;
        @(negedge clk);
        in_valid = '0;
        repeat (N - 1) @(negedge clk);
    endtask

    // reference stream: each count from t0 to last, bytes in ascending sequence order
    task automatic build(input int t0, input int last);
        for (int c = t0; c <= last; c++)
            for (int s = 0; s < N; s++)
                for (int m = 0; m < N; m++)
                    if (seqv[m] == s) begin
                        exp_mfi.push_back(c % 4096);
                        exp_seq.push_back(s);
                        exp_dat.push_back(dfun(m, c));
                    end
    endtask

    // compared on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ovf_alarm) begin
                alarm_cnt++;
                if (mem_depth != '0) alarm_dirty++;
            end
            if (out_valid) begin
                valid_seen++;
                if (first_mfi < 0) first_mfi = int'(out_mfi);
                if (cmp_en) begin
                    if (exp_mfi.size() == 0) begin
                        chk(0, "R4 extra byte", int'(out_data), -1);
                    end else begin
                        int em, es, ed;
                        em = exp_mfi.pop_front();
                        es = exp_seq.pop_front();
                        ed = exp_dat.pop_front();
                        chk(int'(out_mfi) == em, "R4 count", int'(out_mfi), em);
                        chk(int'(out_seq) == es, "R4 sequence", int'(out_seq), es);
                        chk(int'(out_data) == ed, "R4 data", int'(out_data), ed);
                    end
                end
            end
        end
    end

    task automatic run_aligned(input int lag, input int k, input int t0);
        do_reset();
        build(t0, base[lag] + k - 1);
        cmp_en = 1;
        for (int i = 0; i < k; i++) tick(i, '1);
        repeat (150) @(negedge clk);
        chk(first_mfi == t0 % 4096, "R3/R5 first count", first_mfi, t0 % 4096);
        chk(exp_mfi.size() == 0, "R4 all bytes out", exp_mfi.size(), 0);
        for (int m = 0; m < N; m++)
            chk(int'(mem_depth[m]) == base[m] - base[lag], "R6 depth",
                int'(mem_depth[m]), base[m] - base[lag]);
        valid_seen = 0;
        repeat (40) @(negedge clk);
        chk(valid_seen == 0, "R7 stall on empty", valid_seen, 0);
        chk(int'(mem_depth[lag]) == 0, "R7 lag empty", int'(mem_depth[lag]), 0);
    endtask

    initial begin
        seqv = '{0, 1, 2, 3};
        apply_seq();
        do_reset();
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(mem_depth == '0, "R1 depth", 0, 0);
        chk(ovf_alarm == 0, "R1 ovf_alarm", ovf_alarm, 0);
        chk(cfg_err == 0, "R1 cfg_err", cfg_err, 0);

        // R2: single member write
        base = '{5, 5, 5, 5};
        tick(0, 4'b0001);
        chk(int'(mem_depth[0]) == 1, "R2 depth m0", int'(mem_depth[0]), 1);
        chk(int'(mem_depth[1]) == 0, "R2 depth m1", int'(mem_depth[1]), 0);
        chk(valid_seen == 0, "R2 no output", valid_seen, 0);

        // R3/R4/R6/R7: permuted sequence, member 1 most delayed
        seqv = '{2, 0, 3, 1};
        apply_seq();
        base = '{110, 100, 103, 107};
        run_aligned(1, 40, 110);

        // R5: wrap of the 12-bit count, member 2 most delayed
        seqv = '{1, 2, 0, 3};
        apply_seq();
        base = '{4093, 4097, 4090, 4095};
        run_aligned(2, 30, 4097);

        // R8: lead beyond buffer size
        seqv = '{0, 1, 2, 3};
        apply_seq();
        base = '{200, 180, 180, 180};
        do_reset();
        for (int i = 0; i < 40; i++) tick(i, '1);
        chk(alarm_cnt > 0, "R8 alarm raised", alarm_cnt, 1);
        chk(alarm_dirty == 0, "R8 buffers emptied", alarm_dirty, 0);

        // R9: duplicate sequence number, then repaired
        seqv = '{0, 0, 1, 2};
        apply_seq();
        base = '{50, 50, 50, 50};
        do_reset();
        chk(cfg_err == 1, "R9 cfg_err", cfg_err, 1);
        for (int i = 0; i < 6; i++) tick(i, '1);
        chk(valid_seen == 0, "R9 blocked", valid_seen, 0);
        chk(int'(mem_depth[0]) == 6, "R9 writes kept", int'(mem_depth[0]), 6);
        seqv = '{0, 1, 2, 3};
        apply_seq();
        build(50, 55);
        cmp_en = 1;
        repeat (60) @(negedge clk);
        chk(cfg_err == 0, "R9 cfg_err clear", cfg_err, 0);
        chk(exp_mfi.size() == 0, "R9 resumed output", exp_mfi.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule